// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable, parameterized model of a synchronous static RAM. Its pipeline lets reads and writes alternate on every clock with no idle bus cycle between them. Address and control are registered on a rising edge. The data for that command crosses the shared bidirectional bus two enabled clock edges later, and this delay is the same for reads and for writes. The fixed lag is what removes the turnaround gap. A write's data slot and a following read's data slot never overlap, so the bus owner can change on every cycle.

A command starts only on a load cycle in which all three chip enables are asserted. An advance cycle then steps a two-bit burst counter and continues the burst in the direction of its load. The order is either linear or interleaved, picked by a static select pin. Per-lane write selects update only chosen 9-bit lanes of a word. When the active-low clock enable is high, the whole pipeline freezes. The output enable is asynchronous and only gates the data drivers. The array depth is a parameter, kept small enough to simulate.

Top module: `zbt_sram`

## Requirements
- R1: A command captured at an enabled edge k has its data phase in the cycle that ends at the second following enabled edge (k+2). Write data on `dq` is sampled at that edge. Read data is driven during that cycle, holding the word as it stood after all writes sampled up to edge k+1.
- R2: Reads and writes may alternate on consecutive cycles with no idle cycle. A read issued in the cycle right after a write to the same address returns the newly written lanes.
- R3: While `clk_en_n` is 1, all other synchronous inputs are ignored. Every pipeline, burst and output register holds its value, and a read word already on the bus stays unchanged.
- R4: A load is a cycle with `adv_ld`=0. It begins an operation only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Otherwise no operation begins, the memory is not touched, and any burst in progress ends.
- R5: An enabled cycle with `adv_ld`=1 after a started load issues the next burst beat. The two-bit beat count n goes 1, 2, 3 and then wraps to 0, and address bits above the two low bits stay those of the load address.
- R6: With `burst_ilv`=0 the two low address bits of beat n are (start + n) mod 4. With `burst_ilv`=1 they are start XOR n.
- R7: `dq` is driven only during a read data phase while `oe_n`=0. Taking `oe_n` high releases the bus at once, without waiting for a clock edge.
- R8: `byte_we_n[i]`=0 writes lane i, bits 9i+8 down to 9i. These selects are sampled with the command (each burst beat samples its own), and lanes with a select of 1 keep their old contents.
- R9: A burst beat takes the read/write direction of its load, whatever `rw_n` shows. An advance after a deselected load, or after reset, does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en_n | input | 1 | Active-low clock enable; 1 freezes the block |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| rw_n | input | 1 | 1 = read, 0 = write, sampled on a load |
| adv_ld | input | 1 | 0 = load new address, 1 = advance burst |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| byte_we_n | input | LANES | Per-lane write selects, active low |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | inout | LANES*LANE_W | Bidirectional data bus |

## Verification
The reference model is driven with several kinds of traffic. A back-to-back fill shows that write data is taken at the right edge. Random interleaved reads and writes, some to the same address on adjacent cycles, separate correct forwarding from a stale array read. Random stalls inside streams show whether a frozen pipeline holds its read word or slips by one. Directed bursts from each start offset in both orders, including a wrapping read burst, tell the linear and interleaved sequences apart. Deselected loads followed by advances must leave memory untouched. Partial lane writes and mid-phase output-enable toggles separate lane masking and bus release from whole-word behaviour.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } burst_ord_e;

  // Low two address bits of burst beat `cnt` given the start offset.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input burst_ord_e ord);
    if (ord == ORD_INTERLEAVED) return start ^ cnt;
    else                        return start + cnt;
  endfunction

endpackage

// File: rtl/zbt_cmd_dec.sv
module zbt_cmd_dec
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sel,
  input  logic              adv_ld,
  input  logic              rw_n,
  input  logic              burst_ilv,
  input  logic [LANES-1:0]  byte_we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd_v,
  output logic              cmd_wr,
  output logic [ADDR_W-1:0] cmd_a,
  output logic [LANES-1:0]  cmd_be
);

  logic              act_q, act_n;
  logic              wr_q, wr_n;
  logic [ADDR_W-1:0] base_q, base_n;
  logic [1:0]        cnt_q, cnt_n;

  always_comb begin
    act_n  = act_q;
    wr_n   = wr_q;
    base_n = base_q;
    cnt_n  = cnt_q;
    cmd_v  = 1'b0;
    cmd_wr = 1'b0;
    cmd_a  = addr;
    cmd_be = ~byte_we_n;
    if (!adv_ld) begin
      if (sel) begin
        cmd_v  = 1'b1;
        cmd_wr = ~rw_n;
        act_n  = 1'b1;
        wr_n   = ~rw_n;
        base_n = addr;
        cnt_n  = 2'd0;
      end else begin
        act_n  = 1'b0;
      end
    end else if (act_q) begin
      cnt_n  = cnt_q + 2'd1;
      cmd_v  = 1'b1;
      cmd_wr = wr_q;
      cmd_a  = {base_q[ADDR_W-1:2],
                burst_low(base_q[1:0], cnt_n, burst_ord_e'(burst_ilv))};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      act_q  <= act_n;
      wr_q   <= wr_n;
      base_q <= base_n;
      cnt_q  <= cnt_n;
    end
  end

endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cmd_v,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] cmd_a,
  input  logic [LANES-1:0]  cmd_be,
  output logic              s1_v,
  output logic              s1_wr,
  output logic [ADDR_W-1:0] s1_a,
  output logic              s2_v,
  output logic              s2_wr,
  output logic [ADDR_W-1:0] s2_a,
  output logic [LANES-1:0]  s2_be
);

  typedef struct packed {
    logic              v;
    logic              wr;
    logic [ADDR_W-1:0] a;
    logic [LANES-1:0]  be;
  } stage_t;

  stage_t st1_q, st1_n, st2_q, st2_n;

  always_comb begin
    st1_n = st1_q;
    st2_n = st2_q;
    if (en) begin
      st1_n = '{v: cmd_v, wr: cmd_wr, a: cmd_a, be: cmd_be};
      st2_n = st1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= '0;
      st2_q <= '0;
    end else begin
      st1_q <= st1_n;
      st2_q <= st2_n;
    end
  end

  assign s1_v  = st1_q.v;
  assign s1_wr = st1_q.wr;
  assign s1_a  = st1_q.a;
  assign s2_v  = st2_q.v;
  assign s2_wr = st2_q.wr;
  assign s2_a  = st2_q.a;
  assign s2_be = st2_q.be;

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_go,
  input  logic [ADDR_W-1:0] wr_a,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_go,
  input  logic [ADDR_W-1:0] rd_a,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_word;

  // Read path sees the lanes written at the same edge.
  always_comb begin
    rd_word = mem[rd_a];
    if (wr_go && (wr_a == rd_a)) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_be[l]) rd_word[l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en && wr_go) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_be[l]) mem[wr_a][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rdata <= '0;
    else if (en && rd_go)    rdata <= rd_word;
  end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              rw_n,
  input  logic              adv_ld,
  input  logic              burst_ilv,
  input  logic [LANES-1:0]  byte_we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              oe_n,
  inout  wire  [DATA_W-1:0] dq
);

  logic [1:0]        rst_sync_q;
  logic              rst_q_n;
  logic              en;
  logic              sel;
  logic              cmd_v, cmd_wr;
  logic [ADDR_W-1:0] cmd_a;
  logic [LANES-1:0]  cmd_be;
  logic              s1_v, s1_wr, s2_v, s2_wr;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [LANES-1:0]  s2_be;
  logic [DATA_W-1:0] rdata;
  logic              dq_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  assign en  = ~clk_en_n;
  assign sel = ~cs1_n & cs2 & ~cs3_n;

  zbt_cmd_dec #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .clk, .rst_n(rst_q_n), .en, .sel, .adv_ld, .rw_n, .burst_ilv,
    .byte_we_n, .addr, .cmd_v, .cmd_wr, .cmd_a, .cmd_be
  );

  zbt_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk, .rst_n(rst_q_n), .en, .cmd_v, .cmd_wr, .cmd_a, .cmd_be,
    .s1_v, .s1_wr, .s1_a, .s2_v, .s2_wr, .s2_a, .s2_be
  );

  zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk, .rst_n(rst_q_n), .en,
    .wr_go(s2_v & s2_wr), .wr_a(s2_a), .wr_be(s2_be), .wdata(dq),
    .rd_go(s1_v & ~s1_wr), .rd_a(s1_a), .rdata
  );

  assign dq_drive = s2_v & ~s2_wr & ~oe_n;
  assign dq = dq_drive ? rdata : 'z;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          cs1_n,
  input logic          cs2,
  input logic          cs3_n,
  input logic          adv_ld,
  input logic          oe_n,
  input logic          s1_v,
  input logic          s1_wr,
  input logic [AW-1:0] s1_a,
  input logic          s2_v,
  input logic          s2_wr,
  input logic [AW-1:0] s2_a,
  input logic          dq_drive
);

  p_cmd_to_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && s1_v) |=> (s2_v && s2_a == $past(s1_a) && s2_wr == $past(s1_wr)));

  p_stall_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(s1_v) && $stable(s1_wr) && $stable(s1_a) &&
                  $stable(s2_v) && $stable(s2_wr) && $stable(s2_a)));

  p_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && (cs1_n || !cs2 || cs3_n)) |=> !s1_v);

  p_burst_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld && s1_v) |=> (s1_v && s1_wr == $past(s1_wr)));

  p_idle_adv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld && !s1_v) |=> !s1_v);

  p_oe_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_drive);

  always_comb begin
    if (rst_n && oe_n) p_oe_async_r7: assert (!dq_drive);
  end

endmodule

bind zbt_sram zbt_sram_chk #(.AW(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_q_n), .clk_en_n(clk_en_n), .cs1_n(cs1_n), .cs2(cs2),
  .cs3_n(cs3_n), .adv_ld(adv_ld), .oe_n(oe_n), .s1_v(s1_v), .s1_wr(s1_wr),
  .s1_a(s1_a), .s2_v(s2_v), .s2_wr(s2_wr), .s2_a(s2_a), .dq_drive(dq_drive)
);

// File: tb/zbt_sram_tb_top.sv
`timescale 1ns/1ps
module zbt_sram_tb_top;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, clk_en_n, cs1_n, cs2, cs3_n, rw_n, adv_ld, burst_ilv, oe_n;
  logic [LN-1:0] byte_we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] tb_dq;
  logic          tb_drive;
  wire  [DW-1:0] dq;

  assign dq = tb_drive ? tb_dq : 'z;
  for (genvar i = 0; i < DW; i++) begin : g_pu
    pullup (dq[i]);
  end

  zbt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
    .clk, .rst_n, .clk_en_n, .cs1_n, .cs2, .cs3_n, .rw_n, .adv_ld,
    .burst_ilv, .byte_we_n, .addr, .oe_n, .dq
  );

  // Reference model state
  logic [DW-1:0] ref_mem [DEPTH];
  bit      b_act, b_wr;
  int      b_base, b_cnt;
  bit      c_v, c_wr, d_v, d_wr;
  int      c_a, d_a;
  bit [LN-1:0] c_be, d_be;
  string   c_tag, d_tag;
  logic [DW-1:0] d_exp;
  int checks = 0;
  int errors = 0;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One clock of stimulus: desel 0 = all enables on, 1/2/3 = one enable off.
  task automatic cyc(bit cen, int desel, bit rwn, bit adv, bit [LN-1:0] ben,
                     int a, bit oe, string tag);
    int low;
    clk_en_n  = cen;
    cs1_n     = (desel == 1);
    cs2       = (desel != 2);
    cs3_n     = (desel == 3);
    rw_n      = rwn;
    adv_ld    = adv;
    byte_we_n = ben;
    addr      = a[AW-1:0];
    oe_n      = oe;
    if (d_v && d_wr) begin
      tb_dq    = {4'($urandom), 32'($urandom)};
      tb_drive = 1'b1;
    end else begin
      tb_drive = 1'b0;
    end
    #1;
    if (d_v && !d_wr) begin
      if (oe) check("R7", dq, '1);
      else    check(cen ? "R3" : d_tag, dq, d_exp);
    end
    @(posedge clk);
    #1;
    if (!cen) begin
      if (d_v && d_wr)
        for (int l = 0; l < LN; l++)
          if (d_be[l]) ref_mem[d_a][l*LW +: LW] = tb_dq[l*LW +: LW];
      d_v = c_v; d_wr = c_wr; d_a = c_a; d_be = c_be; d_tag = c_tag;
      if (c_v && !c_wr) d_exp = ref_mem[c_a];
      c_be = ~ben; c_tag = tag;
      if (!adv) begin
        if (desel == 0) begin
          c_v = 1; c_wr = !rwn; c_a = a;
          b_act = 1; b_base = a; b_cnt = 0; b_wr = !rwn;
        end else begin
          c_v = 0; b_act = 0;
        end
      end else if (b_act) begin
        b_cnt = (b_cnt + 1) % 4;
        low = burst_ilv ? ((b_base % 4) ^ b_cnt) : ((b_base % 4 + b_cnt) % 4);
        c_a = (b_base / 4) * 4 + low;
        c_v = 1; c_wr = b_wr;
      end else begin
        c_v = 0;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 1, 1, 0, '1, 0, 0, "R4");
  endtask

  task automatic wr(int a, bit [LN-1:0] ben, string tag);
    cyc(0, 0, 0, 0, ben, a, 0, tag);
  endtask

  task automatic rd(int a, string tag);
    cyc(0, 0, 1, 0, '1, a, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1: actual watchdog timeout expected run completion");
    finish_run();
  end

  initial begin
    rst_n = 0; clk_en_n = 0; cs1_n = 1; cs2 = 1; cs3_n = 1; rw_n = 1;
    adv_ld = 1; burst_ilv = 0; byte_we_n = '1; addr = '0; oe_n = 0;
    tb_dq = '0; tb_drive = 0;
    b_act = 0; b_wr = 0; b_base = 0; b_cnt = 0;
    c_v = 0; c_wr = 0; c_a = 0; c_be = '0; c_tag = "";
    d_v = 0; d_wr = 0; d_a = 0; d_be = '0; d_tag = ""; d_exp = '0;
    repeat (3) @(negedge clk);
    #1 check("R7", dq, '1);            // bus released in reset
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1 check("R7", dq, '1);            // nothing in a data phase after reset

    // Back-to-back fill of every word
    for (int a = 0; a < DEPTH; a++) wr(a, '0, "R2");
    idle(2);

    // R1: plain write then read of the same word
    wr(5, '0, "R1"); idle(2); rd(5, "R1"); idle(3);
    // R2: read right after write, same address
    wr(6, '0, "R2"); rd(6, "R2"); wr(6, 4'b0110, "R2"); rd(6, "R2"); idle(3);

    // R8: partial lane write (lanes 0 and 2 written)
    wr(7, '0, "R8"); idle(1); wr(7, 4'b1010, "R8"); idle(2); rd(7, "R8"); idle(3);

    // R4 / R9: deselected writes and idle advances leave memory intact
    wr(9, '0, "R4"); idle(2);
    for (int d = 1; d <= 3; d++) begin
      cyc(0, d, 0, 0, '0, 9, 0, "R4");
      cyc(0, 0, 0, 1, '0, 9, 0, "R9");
    end
    idle(2); rd(9, "R4"); idle(3);

    // R3: stall while a read sits in the pipeline
    rd(11, "R3"); rd(12, "R3");
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, '0, 13, 0, "R3");
    idle(1);
    for (int i = 0; i < 3; i++) cyc(1, 2, 0, 1, '0, 14, 0, "R3");
    idle(3);

    // R7: output enable released mid data phase
    rd(12, "R7"); idle(1); cyc(0, 1, 1, 0, '1, 0, 1, "R7"); idle(3);

    // R5 / R6 / R9: bursts from each start offset in both orders
    for (int o = 0; o < 2; o++) begin
      burst_ilv = o[0];
      for (int s = 0; s < 4; s++) begin
        int base;
        base = 32 + 4 * s + s;
        wr(base, '0, "R9");
        for (int k = 0; k < 3; k++) cyc(0, 0, 1, 1, '0, 0, 0, "R9");
        idle(2);
        rd(base, o ? "R6" : "R5");
        for (int k = 0; k < 5; k++) cyc(0, 0, 0, 1, '1, 0, 0, o ? "R6" : "R5");
        idle(2);
        for (int k = 0; k < 4; k++) rd((base / 4) * 4 + k, "R9");
        idle(3);
      end
    end

    // Random mixed traffic with stalls, bursts and output-enable toggles
    for (int i = 0; i < 3000; i++) begin
      int r;
      bit oe;
      r  = $urandom % 100;
      oe = ($urandom % 10) == 0;
      if (($urandom % 50) == 0 && !c_v && !d_v) burst_ilv = $urandom % 2;
      if (r < 10)
        cyc(1, $urandom % 4, $urandom % 2, $urandom % 2, LN'($urandom), $urandom, oe, "R3");
      else if (r < 25)
        cyc(0, 0, $urandom % 2, 1, LN'($urandom), $urandom, oe, burst_ilv ? "R6" : "R5");
      else if (r < 30)
        cyc(0, 1 + $urandom % 3, $urandom % 2, 0, LN'($urandom), $urandom, oe, "R4");
      else
        cyc(0, 0, $urandom % 2, 0, (($urandom % 4) == 0) ? '0 : LN'($urandom),
            $urandom % DEPTH, oe, "R2");
    end
    idle(4);
    finish_run();
  end

endmodule